// File: doc/BRIEF.md
# Bidirectional Range Lookdown Unit

This unit decides whether a signed target value falls inside a closed range whose two bounds may arrive in either order. Each request also carries a running index. On a hit, the unit returns the target's position within the range, offset by that index. On a miss, it returns the index moved past the whole range. Software or a sequencer can then feed that value back as the index for the next range. This lets a list of ranges be scanned one request at a time until a hit gives the final position.

A request is taken when `in_valid` is high at a rising clock edge. All results are registered and appear together with a one-cycle `out_valid` pulse. The results are:
- a hit flag,
- a flag that records whether the bounds were given in descending order,
- a three-way status,
- the computed value.

All arithmetic is two's-complement and wraps modulo 2^W.

Top module: `rlk_lookdown`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_hit` and `out_desc` are 0, `out_status` is 2'b00 and `out_value` is 0.
- R2: A request sampled with `in_valid` high produces `out_valid` high for exactly the next cycle. Without a request, `out_valid` is low.
- R3: `out_desc` is 1 exactly when `bound_a` is greater than `bound_b`, compared as signed values.
- R4: If `bound_a` ≤ `bound_b` (signed), a hit occurs when `bound_a` ≤ `target` ≤ `bound_b`. The value is then `base_idx + target - bound_a`.
- R5: If `bound_a` > `bound_b` (signed), a hit occurs when `bound_b` ≤ `target` ≤ `bound_a`. The value is then `base_idx + bound_a - target`.
- R6: On a miss, the value is `base_idx` plus the absolute difference of the bounds plus 1, all modulo 2^W.
- R7: Both bounds are inclusive, so a target equal to either bound is a hit.
- R8: `out_status` is 2'b01 when the target equals a bound, 2'b10 when it lies strictly inside, and 2'b00 when it is outside. The value 2'b11 never appears.
- R9: When both bounds are equal, only that one value hits, and a miss advances the index by exactly 1.
- R10: Between requests, all result outputs hold their last values, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| target | input | W | Signed value to locate |
| bound_a | input | W | First range bound (signed) |
| bound_b | input | W | Second range bound (signed) |
| base_idx | input | W | Running index |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_hit | output | 1 | Target lies in the closed range |
| out_desc | output | 1 | `bound_a` was greater than `bound_b` |
| out_status | output | 2 | 01 on a bound, 10 strictly inside, 00 outside |
| out_value | output | W | Position on a hit, advanced index on a miss |

## Verification
The hardest cases to reach are at the signed extremes. There, a range that spans from the most negative to the most positive value forces the span and the offset to wrap. The same region is where a sign error in the compare would turn a hit into a miss. The directed stimulus places bounds and targets at those extremes in both orders, with targets exactly on each bound. A separate phase changes the data inputs while the strobe is low, to show that the results hold.

// File: rtl/rlk_pkg.sv
// Shared types for the range lookdown unit.
package rlk_pkg;
    // Three-way placement of the target relative to the range
    typedef enum logic [1:0] {
        ST_OUT    = 2'b00,
        ST_EDGE   = 2'b01,
        ST_INSIDE = 2'b10
    } rlk_status_t;
endpackage

// File: rtl/rlk_compare.sv
// Orders the two bounds and classifies the target against them.
// Assumes all operands are signed two's-complement values of width W.
module rlk_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0]         target,
    input  logic [W-1:0]         bound_a,
    input  logic [W-1:0]         bound_b,
    output logic                 desc,
    output logic [W-1:0]         lo,
    output logic [W-1:0]         hi,
    output logic                 hit,
    output rlk_pkg::rlk_status_t status
);
    import rlk_pkg::*;

    logic on_edge;

    // Direction, ordered bounds and range membership
    always_comb begin
        desc    = $signed(bound_a) > $signed(bound_b);
        lo      = desc ? bound_b : bound_a;
        hi      = desc ? bound_a : bound_b;
        hit     = ($signed(target) >= $signed(lo)) && ($signed(target) <= $signed(hi));
        on_edge = (target == bound_a) || (target == bound_b);
    end

    // Three-way status encoding
    always_comb begin
        if (!hit)        status = ST_OUT;
        else if (on_edge) status = ST_EDGE;
        else             status = ST_INSIDE;
    end
endmodule

// File: rtl/rlk_arith.sv
// Forms the result value: the offset position on a hit, the advanced index on a miss.
// Assumes lo/hi are the ordered bounds from rlk_compare; arithmetic wraps mod 2^W.
module rlk_arith #(
    parameter int W = 32
) (
    input  logic         desc,
    input  logic         hit,
    input  logic [W-1:0] target,
    input  logic [W-1:0] bound_a,
    input  logic [W-1:0] base_idx,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] offset;
    logic [W-1:0] span;

    // Select the offset by direction and the span from the ordered bounds
    always_comb begin
        offset = desc ? (bound_a - target) : (target - bound_a);
        span   = hi - lo;
        value  = hit ? (base_idx + offset) : (base_idx + span + ONE);
    end
endmodule

// File: rtl/rlk_lookdown.sv
// Top of the bidirectional range lookdown unit. Samples one request per
// in_valid strobe and registers all results with a one-cycle out_valid pulse.
// Assumes a synchronous active-low reset; results hold between requests.
module rlk_lookdown #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] target,
    input  logic [W-1:0] bound_a,
    input  logic [W-1:0] bound_b,
    input  logic [W-1:0] base_idx,
    output logic         out_valid,
    output logic         out_hit,
    output logic         out_desc,
    output logic [1:0]   out_status,
    output logic [W-1:0] out_value
);
    import rlk_pkg::*;

    logic         c_desc;
    logic         c_hit;
    logic [W-1:0] c_lo;
    logic [W-1:0] c_hi;
    logic [W-1:0] c_value;
    rlk_status_t  c_status;

    rlk_compare #(.W(W)) u_cmp (
        .target  (target),
        .bound_a (bound_a),
        .bound_b (bound_b),
        .desc    (c_desc),
        .lo      (c_lo),
        .hi      (c_hi),
        .hit     (c_hit),
        .status  (c_status)
    );

    rlk_arith #(.W(W)) u_arith (
        .desc     (c_desc),
        .hit      (c_hit),
        .target   (target),
        .bound_a  (bound_a),
        .base_idx (base_idx),
        .lo       (c_lo),
        .hi       (c_hi),
        .value    (c_value)
    );

    // Strobe register: one pulse per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers: load on request, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_hit    <= 1'b0;
            out_desc   <= 1'b0;
            out_status <= ST_OUT;
            out_value  <= '0;
        end else if (in_valid) begin
            out_hit    <= c_hit;
            out_desc   <= c_desc;
            out_status <= c_status;
            out_value  <= c_value;
        end
    end
endmodule

// File: rtl/rlk_lookdown_chk.sv
// Checker for rlk_lookdown, attached by bind. Observes ports only.
module rlk_lookdown_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] target,
    input logic [W-1:0] bound_a,
    input logic [W-1:0] bound_b,
    input logic [W-1:0] base_idx,
    input logic         out_valid,
    input logic         out_hit,
    input logic         out_desc,
    input logic [1:0]   out_status,
    input logic [W-1:0] out_value
);
    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    dir_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_desc == ($signed($past(bound_a)) > $signed($past(bound_b)))));

    // R8
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_status != 2'b11);

    // R8
    status_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit == (out_status != 2'b00)));

    // R9
    single_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bound_a == bound_b && target != bound_a)
        |=> (!out_hit && out_value == $past(base_idx) + 1));

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !$past(!rst_n)) |=> ($stable(out_value) && $stable(out_hit)
                         && $stable(out_desc) && $stable(out_status)));
endmodule

bind rlk_lookdown rlk_lookdown_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .target     (target),
    .bound_a    (bound_a),
    .bound_b    (bound_b),
    .base_idx   (base_idx),
    .out_valid  (out_valid),
    .out_hit    (out_hit),
    .out_desc   (out_desc),
    .out_status (out_status),
    .out_value  (out_value)
);

// File: tb/tb_rlk_lookdown.sv
// Directed bench for rlk_lookdown: one task per scenario, each checking its own results.
module tb_rlk_lookdown;
    localparam int W = 32;
    localparam time CLK_PERIOD = 10ns;
    localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] target = '0, bound_a = '0, bound_b = '0, base_idx = '0;
    logic         out_valid, out_hit, out_desc;
    logic [1:0]   out_status;
    logic [W-1:0] out_value;

    int checks = 0;
    int errors = 0;

    rlk_lookdown #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .target(target), .bound_a(bound_a), .bound_b(bound_b), .base_idx(base_idx),
        .out_valid(out_valid), .out_hit(out_hit), .out_desc(out_desc),
        .out_status(out_status), .out_value(out_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one request and compare all outputs with values worked out from the requirements
    task automatic run(input string req, input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                       input logic signed [W-1:0] t, input logic [W-1:0] idx);
        logic         e_desc, e_hit;
        logic [1:0]   e_st;
        logic [W-1:0] e_val, gap;
        e_desc = a > b;
        if (!e_desc) e_hit = (t >= a) && (t <= b);
        else         e_hit = (t <= a) && (t >= b);
        if (!e_hit)                 e_st = 2'b00;
        else if (t == a || t == b)  e_st = 2'b01;
        else                        e_st = 2'b10;
        gap = e_desc ? (a - b) : (b - a);
        if (e_hit) e_val = e_desc ? (idx + a - t) : (idx + t - a);
        else       e_val = idx + gap + 1;
        @(negedge clk);
        bound_a = a; bound_b = b; target = t; base_idx = idx; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "out_valid", {{(W-1){1'b0}}, out_valid}, 1);
        chk(req, "out_desc",  {{(W-1){1'b0}}, out_desc},  {{(W-1){1'b0}}, e_desc});
        chk(req, "out_hit",   {{(W-1){1'b0}}, out_hit},   {{(W-1){1'b0}}, e_hit});
        chk(req, "out_status", {{(W-2){1'b0}}, out_status}, {{(W-2){1'b0}}, e_st});
        chk(req, "out_value", out_value, e_val);
        @(negedge clk);
        chk("R2", "out_valid low after pulse", {{(W-1){1'b0}}, out_valid}, 0);
    endtask

    task automatic t_reset();
        chk("R1", "out_valid", {{(W-1){1'b0}}, out_valid}, 0);
        chk("R1", "out_hit",   {{(W-1){1'b0}}, out_hit},   0);
        chk("R1", "out_desc",  {{(W-1){1'b0}}, out_desc},  0);
        chk("R1", "out_status", {{(W-2){1'b0}}, out_status}, 0);
        chk("R1", "out_value", out_value, 0);
    endtask

    task automatic t_ascending();
        run("R4", 10, 20, 15, 100);
        run("R4", -8, 5, -3, 7);
        run("R6", 10, 20, 25, 100);
        run("R6", 10, 20, 9, 0);
    endtask

    task automatic t_descending();
        run("R5", 20, 10, 15, 100);
        run("R5", 5, -8, -7, 1);
        run("R6", 20, 10, 5, 50);
        run("R6", 5, -8, 6, 3);
    endtask

    task automatic t_edges();
        run("R7", 10, 20, 10, 0);
        run("R7", 10, 20, 20, 0);
        run("R7", 20, 10, 10, 4);
        run("R7", 20, 10, 20, 4);
        run("R8", 10, 20, 11, 0);
    endtask

    task automatic t_single();
        run("R9", 42, 42, 42, 9);
        run("R9", 42, 42, 43, 9);
        run("R9", -1, -1, 0, 32'hFFFF_FFFF);
    endtask

    task automatic t_extremes();
        run("R4", SMIN, SMAX, 0, 0);
        run("R5", SMAX, SMIN, SMIN, 0);
        run("R6", SMIN, SMAX - 1, SMAX, 5);
        run("R3", -1, -2, -1, 0);
    endtask

    // Change data inputs with the strobe low and confirm every result holds
    task automatic t_hold();
        logic [W-1:0] v;
        logic [1:0]   s;
        logic         h, d;
        run("R10", 20, 10, 12, 3);
        v = out_value; s = out_status; h = out_hit; d = out_desc;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bound_a = 32'(i * 7); bound_b = 32'(-i); target = 32'(i); base_idx = 32'(i * 100);
        end
        @(negedge clk);
        chk("R10", "value held",  out_value, v);
        chk("R10", "status held", {{(W-2){1'b0}}, out_status}, {{(W-2){1'b0}}, s});
        chk("R10", "hit held",    {{(W-1){1'b0}}, out_hit}, {{(W-1){1'b0}}, h});
        chk("R10", "desc held",   {{(W-1){1'b0}}, out_desc}, {{(W-1){1'b0}}, d});
        chk("R2", "no strobe while idle", {{(W-1){1'b0}}, out_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ascending();
        t_descending();
        t_edges();
        t_single();
        t_extremes();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule